// File: doc/BRIEF.md
# Aliased Multi-Width Register File

This block is a small register file whose whole contents live in one array of bytes. Sixteen general-purpose bytes sit at the bottom of that array and four accumulator bytes sit directly above them. Every access names a width (byte, 16-bit word or 32-bit dword) and an index counted in units of that width. Because all three views are windows onto the same bytes, a value written at one width is immediately seen through the others. For example, writing two bytes and then reading the word that holds them returns both bytes.

There are two combinational read ports and one clocked write port. Each port has its own width select and index. Narrow reads are zero-extended to 32 bits. An access whose index lies beyond the storage for its width is harmless: a read returns zero and a write does nothing. An execution unit uses the block as its operand store. The decoded register field and the operand-size field drive the ports directly, with no size-dependent remapping outside the block.

Top module: `aliased_regfile`

## Requirements
- R1: Width select 2'b00 is the byte view. Index k (0 to 19) returns storage byte k in bits [7:0], and bits [31:8] read zero.
- R2: Width select 2'b01 is the word view. Index k (0 to 9) returns byte 2k in bits [7:0] and byte 2k+1 in bits [15:8], and bits [31:16] read zero.
- R3: Width select 2'b10 is the dword view. Index k (0 to 4) returns bytes 4k to 4k+3, with the lowest-numbered byte in bits [7:0].
- R4: Bytes 16 to 19 form the accumulator. It is reachable as byte indices 16 to 19, as word indices 8 (low half) and 9 (high half), and as dword index 4.
- R5: A write at any width is visible through every other width that overlaps it, starting from the cycle after the write edge.
- R6: A word or dword write updates every byte it covers on the same clock edge and leaves all other bytes unchanged.
- R7: Reads are combinational. During a cycle that carries a write, both read ports return the pre-write contents, and two ports addressing the same storage return equal data.
- R8: A read returns zero when the width select is 2'b11 or when the index is at least 20 (byte), 10 (word) or 5 (dword).
- R9: A write under the same conditions as R8 changes no storage byte.
- R10: An active-low reset clears every storage byte to zero, asynchronously.
- R11: A write uses only the low 8 bits (byte) or the low 16 bits (word) of the write data, and ignores the upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 2 | Write width select (00 byte, 01 word, 10 dword, 11 reserved) |
| wr_idx | input | 5 | Write index in units of the selected width |
| wr_data | input | 32 | Write data, least significant byte first |
| ra_sel | input | 2 | Read port A width select |
| ra_idx | input | 5 | Read port A index |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_sel | input | 2 | Read port B width select |
| rb_idx | input | 5 | Read port B index |
| rb_data | output | 32 | Read port B data, zero-extended |

## Verification
The vector table writes at one width and reads back at a different width. A byte pair read as a word, or words read as a dword, exposes lane-ordering mistakes that a same-width readback would hide. Some writes carry junk in their unused upper data bits, which separates correct lane selection from a plain copy of the data bus. Indices just past each width's limit and the reserved select show whether the range decode is off by one and whether stray writes are dropped. Reading during a write cycle distinguishes combinational reads of old contents from accidental write-through. A directed sequence puts a word write next to already-written bytes to show that neighbouring bytes survive.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [1:0] {
    RW_BYTE  = 2'b00,
    RW_WORD  = 2'b01,
    RW_DWORD = 2'b10,
    RW_RSVD  = 2'b11
  } rw_width_e;

  localparam int unsigned LANES  = 4;
  localparam int unsigned DATA_W = LANES * 8;

endpackage

// File: rtl/rf_addr_decode.sv
module rf_addr_decode #(
  parameter int unsigned IDX_W       = 5,
  parameter int unsigned TOTAL_BYTES = 20,
  parameter int unsigned BASE_W      = IDX_W + 2
) (
  input  logic [1:0]        sel,
  input  logic [IDX_W-1:0]  idx,
  output logic              valid,
  output logic [BASE_W-1:0] base,
  output logic [2:0]        nbytes
);
  import rf_pkg::*;

  localparam logic [BASE_W-1:0] LIM_B = BASE_W'(TOTAL_BYTES);
  localparam logic [BASE_W-1:0] LIM_W = BASE_W'(TOTAL_BYTES / 2);
  localparam logic [BASE_W-1:0] LIM_D = BASE_W'(TOTAL_BYTES / 4);

  logic [BASE_W-1:0] idx_ext;
  assign idx_ext = BASE_W'(idx);

  always_comb begin
    valid  = 1'b0;
    base   = '0;
    nbytes = 3'd0;
    case (rw_width_e'(sel))
      RW_BYTE: begin
        valid  = idx_ext < LIM_B;
        base   = idx_ext;
        nbytes = 3'd1;
      end
      RW_WORD: begin
        valid  = idx_ext < LIM_W;
        base   = idx_ext << 1;
        nbytes = 3'd2;
      end
      RW_DWORD: begin
        valid  = idx_ext < LIM_D;
        base   = idx_ext << 2;
        nbytes = 3'd4;
      end
      default: begin
        valid  = 1'b0;
        base   = '0;
        nbytes = 3'd0;
      end
    endcase
  end

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int unsigned TOTAL_BYTES = 20,
  parameter int unsigned BASE_W      = 7
) (
  input  logic [TOTAL_BYTES*8-1:0]   store,
  input  logic                       valid,
  input  logic [BASE_W-1:0]          base,
  input  logic [2:0]                 nbytes,
  output logic [rf_pkg::DATA_W-1:0]  data
);
  import rf_pkg::*;

  for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
    logic [BASE_W-1:0] lane_addr;
    logic              lane_on;
    logic [7:0]        lane_byte;

    assign lane_addr = base + BASE_W'(l);
    assign lane_on   = valid && (3'(l) < nbytes);

    always_comb begin
      lane_byte = 8'h00;
      if (lane_on) begin
        for (int i = 0; i < int'(TOTAL_BYTES); i++) begin
          if (BASE_W'(i) == lane_addr) lane_byte = store[i*8 +: 8];
        end
      end
    end

    assign data[l*8 +: 8] = lane_byte;
  end

endmodule

// File: rtl/rf_byte_store.sv
module rf_byte_store #(
  parameter int unsigned TOTAL_BYTES = 20,
  parameter int unsigned BASE_W      = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_valid,
  input  logic [BASE_W-1:0]         wr_base,
  input  logic [2:0]                wr_nbytes,
  input  logic [rf_pkg::DATA_W-1:0] wr_data,
  output logic [TOTAL_BYTES*8-1:0]  store_q
);

  logic [7:0] byte_q [TOTAL_BYTES];
  logic [7:0] byte_d [TOTAL_BYTES];
  logic       byte_en [TOTAL_BYTES];

  for (genvar g = 0; g < int'(TOTAL_BYTES); g++) begin : g_byte
    logic [BASE_W-1:0] off;
    logic              covered;

    assign off     = BASE_W'(g) - wr_base;
    assign covered = (BASE_W'(g) >= wr_base) && (off < BASE_W'(wr_nbytes));

    // next state: clock enable and selected lane of the write bus
    always_comb begin
      byte_en[g] = wr_en && wr_valid && covered;
      byte_d[g]  = wr_data[{off[1:0], 3'b000} +: 8];
    end

    // register
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[g] <= 8'h00;
      end else if (byte_en[g]) begin
        byte_q[g] <= byte_d[g];
      end
    end

    assign store_q[g*8 +: 8] = byte_q[g];
  end

endmodule

// File: rtl/aliased_regfile.sv
module aliased_regfile #(
  parameter int unsigned GP_BYTES  = 16,
  parameter int unsigned ACC_BYTES = 4,
  parameter int unsigned IDX_W     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [1:0]  ra_sel,
  input  logic [4:0]  ra_idx,
  output logic [31:0] ra_data,
  input  logic [1:0]  rb_sel,
  input  logic [4:0]  rb_idx,
  output logic [31:0] rb_data
);
  import rf_pkg::*;

  localparam int unsigned TOTAL_BYTES = GP_BYTES + ACC_BYTES;
  localparam int unsigned BASE_W      = IDX_W + 2;
  localparam int unsigned N_RD        = 2;

  logic [TOTAL_BYTES*8-1:0] store_flat;

  // write side
  logic              w_valid;
  logic [BASE_W-1:0] w_base;
  logic [2:0]        w_nbytes;

  rf_addr_decode #(
    .IDX_W      (IDX_W),
    .TOTAL_BYTES(TOTAL_BYTES),
    .BASE_W     (BASE_W)
  ) u_wr_dec (
    .sel   (wr_sel),
    .idx   (IDX_W'(wr_idx)),
    .valid (w_valid),
    .base  (w_base),
    .nbytes(w_nbytes)
  );

  rf_byte_store #(
    .TOTAL_BYTES(TOTAL_BYTES),
    .BASE_W     (BASE_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_valid (w_valid),
    .wr_base  (w_base),
    .wr_nbytes(w_nbytes),
    .wr_data  (wr_data),
    .store_q  (store_flat)
  );

  // read side
  logic [1:0]        rd_sel  [N_RD];
  logic [IDX_W-1:0]  rd_idx  [N_RD];
  logic [DATA_W-1:0] rd_data [N_RD];

  assign rd_sel[0] = ra_sel;
  assign rd_idx[0] = IDX_W'(ra_idx);
  assign rd_sel[1] = rb_sel;
  assign rd_idx[1] = IDX_W'(rb_idx);

  for (genvar p = 0; p < int'(N_RD); p++) begin : g_rd
    logic              r_valid;
    logic [BASE_W-1:0] r_base;
    logic [2:0]        r_nbytes;

    rf_addr_decode #(
      .IDX_W      (IDX_W),
      .TOTAL_BYTES(TOTAL_BYTES),
      .BASE_W     (BASE_W)
    ) u_dec (
      .sel   (rd_sel[p]),
      .idx   (rd_idx[p]),
      .valid (r_valid),
      .base  (r_base),
      .nbytes(r_nbytes)
    );

    rf_read_port #(
      .TOTAL_BYTES(TOTAL_BYTES),
      .BASE_W     (BASE_W)
    ) u_port (
      .store (store_flat),
      .valid (r_valid),
      .base  (r_base),
      .nbytes(r_nbytes),
      .data  (rd_data[p])
    );
  end

  assign ra_data = rd_data[0];
  assign rb_data = rd_data[1];

endmodule

// File: rtl/aliased_regfile_checker.sv
module aliased_regfile_checker #(
  parameter int unsigned TOTAL_BYTES = 20
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [1:0]               wr_sel,
  input logic [4:0]               wr_idx,
  input logic [31:0]              wr_data,
  input logic [1:0]               ra_sel,
  input logic [4:0]               ra_idx,
  input logic [31:0]              ra_data,
  input logic [1:0]               rb_sel,
  input logic [4:0]               rb_idx,
  input logic [31:0]              rb_data,
  input logic [TOTAL_BYTES*8-1:0] store_flat
);

  localparam logic [4:0] LIM_B = 5'(TOTAL_BYTES);
  localparam logic [4:0] LIM_W = 5'(TOTAL_BYTES / 2);
  localparam logic [4:0] LIM_D = 5'(TOTAL_BYTES / 4);

  logic ra_oor;
  logic wr_oor;
  assign ra_oor = (ra_sel == 2'b11) ||
                  (ra_sel == 2'b00 && ra_idx >= LIM_B) ||
                  (ra_sel == 2'b01 && ra_idx >= LIM_W) ||
                  (ra_sel == 2'b10 && ra_idx >= LIM_D);
  assign wr_oor = (wr_sel == 2'b11) ||
                  (wr_sel == 2'b00 && wr_idx >= LIM_B) ||
                  (wr_sel == 2'b01 && wr_idx >= LIM_W) ||
                  (wr_sel == 2'b10 && wr_idx >= LIM_D);

  assert_byte_zext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_sel == 2'b00) |-> (ra_data[31:8] == 24'h0));

  assert_word_zext_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_sel == 2'b01) |-> (rb_data[31:16] == 16'h0));

  assert_byte_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 2'b00 && wr_idx < LIM_B) |=>
      (store_flat[{$past(wr_idx), 3'b000} +: 8] == $past(wr_data[7:0])));

  assert_read_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ra_sel) && $stable(ra_idx) && !$past(wr_en)) |-> $stable(ra_data));

  assert_ports_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_sel == rb_sel && ra_idx == rb_idx) |-> (ra_data == rb_data));

  assert_oor_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ra_oor |-> (ra_data == 32'h0));

  assert_oor_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_oor) |=> $stable(store_flat));

endmodule

bind aliased_regfile aliased_regfile_checker #(
  .TOTAL_BYTES(GP_BYTES + ACC_BYTES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .ra_sel    (ra_sel),
  .ra_idx    (ra_idx),
  .ra_data   (ra_data),
  .rb_sel    (rb_sel),
  .rb_idx    (rb_idx),
  .rb_data   (rb_data),
  .store_flat(store_flat)
);

// File: tb/aliased_regfile_tb_top.sv
`timescale 1ns/1ps
module aliased_regfile_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic [1:0]  ra_sel;
  logic [4:0]  ra_idx;
  logic [31:0] ra_data;
  logic [1:0]  rb_sel;
  logic [4:0]  rb_idx;
  logic [31:0] rb_data;

  int checks = 0;
  int errors = 0;

  aliased_regfile dut_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_sel (wr_sel),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .ra_sel (ra_sel),
    .ra_idx (ra_idx),
    .ra_data(ra_data),
    .rb_sel (rb_sel),
    .rb_idx (rb_idx),
    .rb_data(rb_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // row: {we, wsel, widx, wdata, rsel, ridx, expected port A before the edge}
  localparam int NV = 17;
  localparam logic [78:0] VEC [0:NV-1] = '{
    {1'b1, 2'd0, 5'd0,  32'hFFFFFF11, 2'd0, 5'd0,  32'h00000000}, // R11 R7
    {1'b1, 2'd0, 5'd1,  32'h00000022, 2'd1, 5'd0,  32'h00000011}, // R2 R7
    {1'b0, 2'd0, 5'd0,  32'h00000000, 2'd1, 5'd0,  32'h00002211}, // R2 R5
    {1'b1, 2'd1, 5'd1,  32'hDEAD4433, 2'd0, 5'd0,  32'h00000011}, // R1
    {1'b0, 2'd0, 5'd0,  32'h00000000, 2'd2, 5'd0,  32'h44332211}, // R3 R11
    {1'b1, 2'd2, 5'd1,  32'h88776655, 2'd0, 5'd3,  32'h00000044}, // R1 R5
    {1'b0, 2'd0, 5'd0,  32'h00000000, 2'd1, 5'd3,  32'h00008877}, // R6
    {1'b1, 2'd0, 5'd19, 32'h000000A4, 2'd2, 5'd4,  32'h00000000}, // R4
    {1'b1, 2'd1, 5'd8,  32'h0000A2A1, 2'd0, 5'd19, 32'h000000A4}, // R4
    {1'b0, 2'd0, 5'd0,  32'h00000000, 2'd2, 5'd4,  32'hA400A2A1}, // R4 R5
    {1'b1, 2'd0, 5'd20, 32'h000000EE, 2'd0, 5'd20, 32'h00000000}, // R8
    {1'b1, 2'd1, 5'd10, 32'h0000BEEF, 2'd1, 5'd9,  32'h0000A400}, // R9
    {1'b1, 2'd2, 5'd5,  32'h12345678, 2'd2, 5'd4,  32'hA400A2A1}, // R9
    {1'b1, 2'd3, 5'd0,  32'hFFFFFFFF, 2'd3, 5'd0,  32'h00000000}, // R8
    {1'b0, 2'd0, 5'd0,  32'h00000000, 2'd2, 5'd0,  32'h44332211}, // R9
    {1'b1, 2'd2, 5'd0,  32'hCAFEF00D, 2'd2, 5'd0,  32'h44332211}, // R7
    {1'b0, 2'd0, 5'd0,  32'h00000000, 2'd0, 5'd2,  32'h000000FE}  // R5
  };

  function automatic string row_tag(int r);
    case (r)
      0:  return "R11";
      1:  return "R7";
      2:  return "R2";
      3:  return "R1";
      4:  return "R3";
      5:  return "R5";
      6:  return "R6";
      7, 8, 9: return "R4";
      10: return "R8";
      11, 12, 14: return "R9";
      13: return "R8";
      15: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %08h expected %08h", tag, what, got, exp);
    end
  endtask

  task automatic set_write(input logic en, input logic [1:0] s,
                           input logic [4:0] i, input logic [31:0] d);
    wr_en = en; wr_sel = s; wr_idx = i; wr_data = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    set_write(1'b0, 2'd0, 5'd0, 32'h0);
    ra_sel = 2'd0; ra_idx = 5'd0;
    rb_sel = 2'd0; rb_idx = 5'd0;
    repeat (3) @(negedge clk);

    // R10: storage cleared by reset
    for (int k = 0; k < 5; k++) begin
      ra_sel = 2'd2; ra_idx = 5'(k);
      #1;
      check("R10", "reset dword", ra_data, 32'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // vector table
    for (int r = 0; r < NV; r++) begin
      @(negedge clk);
      set_write(VEC[r][78], VEC[r][77:76], VEC[r][75:71], VEC[r][70:39]);
      ra_sel = VEC[r][38:37];
      ra_idx = VEC[r][36:32];
      #2;
      check(row_tag(r), $sformatf("table row %0d", r), ra_data, VEC[r][31:0]);
    end
    @(negedge clk);
    set_write(1'b0, 2'd0, 5'd0, 32'h0);

    // R6: word write beside earlier byte writes
    set_write(1'b1, 2'd0, 5'd8, 32'h0000005A);
    @(negedge clk);
    set_write(1'b1, 2'd0, 5'd11, 32'h0000003C);
    @(negedge clk);
    set_write(1'b1, 2'd1, 5'd5, 32'h00001234);
    @(negedge clk);
    set_write(1'b0, 2'd0, 5'd0, 32'h0);
    ra_sel = 2'd2; ra_idx = 5'd2;
    #2;
    check("R6", "dword 2 after word 5 write", ra_data, 32'h1234005A);

    // R7: both ports on word 0 during a write, then after the edge
    @(negedge clk);
    set_write(1'b1, 2'd1, 5'd0, 32'h00009999);
    ra_sel = 2'd1; ra_idx = 5'd0;
    rb_sel = 2'd1; rb_idx = 5'd0;
    #2;
    check("R7", "port A in write cycle", ra_data, 32'h0000F00D);
    check("R7", "port B in write cycle", rb_data, 32'h0000F00D);
    @(negedge clk);
    set_write(1'b0, 2'd0, 5'd0, 32'h0);
    rb_sel = 2'd0; rb_idx = 5'd1;
    #2;
    check("R7", "port A after edge", ra_data, 32'h00009999);
    check("R5", "port B byte 1 after word write", rb_data, 32'h00000099);

    // R8: port B beyond byte range, R3 on port B
    rb_sel = 2'd0; rb_idx = 5'd25;
    #1;
    check("R8", "port B byte 25", rb_data, 32'h0);
    rb_sel = 2'd2; rb_idx = 5'd1;
    #1;
    check("R3", "port B dword 1", rb_data, 32'h88776655);

    // R10: reset in mid-run acts without a clock edge
    @(negedge clk);
    rst_n = 1'b0;
    ra_sel = 2'd2; ra_idx = 5'd0;
    #1;
    check("R10", "dword 0 during reset", ra_data, 32'h0);
    check("R10", "port B dword 1 during reset", rb_data, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule